// File: doc/BRIEF.md
# Programmable 32-bit CRC engine

This block is a register-mapped CRC unit. Software programs a generator polynomial, seeds a running checksum and loads a word count. It then pushes 32-bit data words into a small input queue and sets the enable bit. The engine takes one word per clock from the queue, optionally mirrors it, and folds it into the running checksum most-significant bit first. When the word count runs out, the engine copies the running checksum into a result register and raises a completion flag. In compute mode it also compares that result against a programmed value. In verify mode each word is checked against that value instead.

A write to the polynomial register restarts an internal preparation phase that lasts a fixed number of cycles. No word is taken until it has finished, and a status bit reports when it is ready. Status flags are cleared by writing 1 to them. An interrupt line combines the flagged events that software has enabled.

Register word addresses: 0 control, 1 word count, 2 compare value, 3 polynomial, 4 running checksum (seed), 5 data input (write only), 6 status, 7 interrupt-enable set, 8 interrupt-enable clear, 9 result (read only). Control layout: bit 0 enable, bits 7:4 mode (1 copy, 2 fill, 3 compute, 4 verify), bit 16 reverse bits within each byte of the input, bit 17 reverse byte order of the input, bit 18 swap input 16-bit halves (applied in that order), bit 20 mirror result readout, bit 21 mirror polynomial, bit 22 mirror compare value. Status layout: bit 1 compare error, bit 4 count expired, bit 8 input overflow, bit 16 input queue has room, bit 19 polynomial ready.

Top module: `crc_engine`

## Requirements
- R1: After reset the control register reads 0, status reads 32'h0009_0000 (queue has room and polynomial ready), the polynomial reads 32'h04C1_1DB7 and irq is low.
- R2: In modes 3 and 1, each consumed word d updates the running checksum c as c = fold(c ^ d) over 32 steps of shift-left with the polynomial XORed in when the bit leaving at bit 31 is 1; after the count expires, the result register holds the final checksum.
- R3: Writing address 4 loads both the running checksum and the result register, so with zero words the result equals the seed.
- R4: Control bits 16, 17 and 18 reverse bits within each byte, reverse byte order and swap 16-bit halves of each input word, in that order, before it is folded or compared.
- R5: Control bit 20 bit-reverses the result readout, bit 21 bit-reverses the polynomial used, bit 22 bit-reverses the compare value used.
- R6: Each consumed word decrements the count; the word that takes it from 1 to 0 sets status bit 4, and words beyond the count stay queued.
- R7: In mode 3, status bit 1 is set at expiry when the result differs from the compare value; in mode 4 it is set by any consumed word that differs from the compare value.
- R8: While control bit 0 is clear no word is consumed and the count holds.
- R9: After a polynomial write, status bit 19 is low and no word is consumed for LUT_CYCLES cycles, then bit 19 returns high.
- R10: The input queue holds FIFO_DEPTH (4) words; when full, status bit 16 is low, further data writes are dropped and set sticky status bit 8.
- R11: Writing 1 to status bits 1, 4 or 8 clears that bit only; bits written 0 are unchanged.
- R12: irq is the OR of status bits 1 and 4 each gated by its enable bit; writing address 7 sets and address 8 clears only the enable bits written as 1, and both read back the enables.
- R13: In mode 2 words are consumed and counted but the running checksum is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The checksum path is exercised with word streams of one to three words under each mirroring option alone and in combination, with all-zero, all-one, single-set-bit and counting-byte patterns, and with several polynomials and seeds. A bit-within-byte error, a byte-order error or a half-swap error each change a different one of these results, and the mirrored-polynomial case with the reversed value of a known polynomial separates a polynomial-mirror fault from a result-mirror fault. Directed cases cover more words than the count, a full queue, a held enable, the preparation window after a polynomial write, matching and mismatching compares in both compare modes, and the fill mode that must leave the checksum untouched.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

   localparam int DW      = 32;
   localparam int ADDR_W  = 4;

   typedef enum logic [3:0] {
      MODE_OFF    = 4'd0,
      MODE_COPY   = 4'd1,
      MODE_FILL   = 4'd2,
      MODE_CALC   = 4'd3,
      MODE_VERIFY = 4'd4
   } crc_mode_e;

   localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
   localparam logic [ADDR_W-1:0] A_COUNT  = 4'd1;
   localparam logic [ADDR_W-1:0] A_CMP    = 4'd2;
   localparam logic [ADDR_W-1:0] A_POLY   = 4'd3;
   localparam logic [ADDR_W-1:0] A_CUR    = 4'd4;
   localparam logic [ADDR_W-1:0] A_DATA   = 4'd5;
   localparam logic [ADDR_W-1:0] A_STAT   = 4'd6;
   localparam logic [ADDR_W-1:0] A_IENSET = 4'd7;
   localparam logic [ADDR_W-1:0] A_IENCLR = 4'd8;
   localparam logic [ADDR_W-1:0] A_RESULT = 4'd9;

   // control bit positions
   localparam int C_EN    = 0;
   localparam int C_BITM  = 16;
   localparam int C_BYTM  = 17;
   localparam int C_HSWP  = 18;
   localparam int C_RESM  = 20;
   localparam int C_POLYM = 21;
   localparam int C_CMPM  = 22;

   // status bit positions
   localparam int S_CERR  = 1;
   localparam int S_EXP   = 4;
   localparam int S_OVF   = 8;
   localparam int S_ROOM  = 16;
   localparam int S_READY = 19;

   localparam logic [DW-1:0] IEN_MASK = (DW'(1) << S_CERR) | (DW'(1) << S_EXP);

   function automatic logic [DW-1:0] rev_bits(input logic [DW-1:0] v);
      logic [DW-1:0] r;
      for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
      return r;
   endfunction

endpackage

// File: rtl/crc_word_mirror.sv
module crc_word_mirror #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] din,
   input  logic          bit_rev,
   input  logic          byte_rev,
   input  logic          half_swap,
   output logic [DW-1:0] dout
);
   localparam int NB = DW / 8;
   localparam int HW = DW / 2;

   logic [DW-1:0] s_bits;
   logic [DW-1:0] s_bytes;

   if ((DW % 16) != 0) begin : g_bad_width
      $error("crc_word_mirror: DW must be a multiple of 16");
   end

   for (genvar b = 0; b < NB; b++) begin : g_byte
      for (genvar k = 0; k < 8; k++) begin : g_bit
         assign s_bits[b*8+k] = bit_rev ? din[b*8+7-k] : din[b*8+k];
      end
      assign s_bytes[b*8 +: 8] = byte_rev ? s_bits[(NB-1-b)*8 +: 8] : s_bits[b*8 +: 8];
   end

   assign dout = half_swap ? {s_bytes[HW-1:0], s_bytes[DW-1:HW]} : s_bytes;

endmodule

// File: rtl/crc_fold.sv
module crc_fold #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] crc_in,
   input  logic [DW-1:0] word,
   input  logic [DW-1:0] poly,
   output logic [DW-1:0] crc_out
);
   function automatic logic [DW-1:0] fold_word(input logic [DW-1:0] c,
                                               input logic [DW-1:0] d,
                                               input logic [DW-1:0] p);
      logic [DW-1:0] acc;
      acc = c ^ d;
      for (int i = 0; i < DW; i++) begin
         if (acc[DW-1]) acc = (acc << 1) ^ p;
         else           acc = acc << 1;
      end
      return acc;
   endfunction

   always_comb crc_out = fold_word(crc_in, word, poly);

endmodule

// File: rtl/crc_in_fifo.sv
module crc_in_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [DW-1:0]              din,
   input  logic                       pop,
   output logic [DW-1:0]              dout,
   output logic                       full,
   output logic                       empty,
   output logic [$clog2(DEPTH+1)-1:0] level
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH+1);

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          do_push, do_pop;

   if (DEPTH < 2) begin : g_bad_depth
      $error("crc_in_fifo: DEPTH must be at least 2");
   end

   assign full    = (level == CW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
         if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
         if (do_push && !do_pop)      level <= level + 1'b1;
         else if (do_pop && !do_push) level <= level - 1'b1;
      end
   end

endmodule

// File: rtl/crc_engine.sv
module crc_engine
   import crc_eng_pkg::*;
#(
   parameter int          FIFO_DEPTH = 4,
   parameter int          LUT_CYCLES = 8,
   parameter logic [31:0] POLY_RESET = 32'h04C1_1DB7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [3:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq
);
   localparam int LVL_W = $clog2(FIFO_DEPTH+1);
   localparam int LCW   = $clog2(LUT_CYCLES+1);

   if (LUT_CYCLES < 1) begin : g_bad_lut
      $error("crc_engine: LUT_CYCLES must be at least 1");
   end

   logic [DW-1:0]    ctrl_q, cnt_q, cmp_q, poly_q, run_q, res_q, ien_q;
   logic             st_cerr, st_exp, st_ovf;
   logic [LCW-1:0]   lut_cnt;
   logic             lut_done;

   logic             wr_ctrl, wr_cnt, wr_cmp, wr_poly, wr_cur, wr_data, wr_stat, wr_iset, wr_iclr;
   logic [DW-1:0]    fifo_dout, word_m, poly_eff, cmp_eff, fold_out, run_next, st_vec;
   logic             fifo_full, fifo_empty, pop, folds, expire;
   logic [LVL_W-1:0] fifo_level;
   crc_mode_e        mode;

   // register write decode
   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign wr_cnt  = bus_wr && (bus_addr == A_COUNT);
   assign wr_cmp  = bus_wr && (bus_addr == A_CMP);
   assign wr_poly = bus_wr && (bus_addr == A_POLY);
   assign wr_cur  = bus_wr && (bus_addr == A_CUR);
   assign wr_data = bus_wr && (bus_addr == A_DATA);
   assign wr_stat = bus_wr && (bus_addr == A_STAT);
   assign wr_iset = bus_wr && (bus_addr == A_IENSET);
   assign wr_iclr = bus_wr && (bus_addr == A_IENCLR);

   assign mode     = crc_mode_e'(ctrl_q[7:4]);
   assign lut_done = (lut_cnt == '0);
   assign pop      = ctrl_q[C_EN] && !fifo_empty && (cnt_q != '0) && lut_done;
   assign folds    = (mode == MODE_CALC) || (mode == MODE_COPY);
   assign expire   = pop && (cnt_q == DW'(1)) && !wr_cnt;
   assign poly_eff = ctrl_q[C_POLYM] ? rev_bits(poly_q) : poly_q;
   assign cmp_eff  = ctrl_q[C_CMPM]  ? rev_bits(cmp_q)  : cmp_q;
   assign run_next = (pop && folds) ? fold_out : run_q;

   crc_in_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_data),
      .din   (bus_wdata),
      .pop   (pop),
      .dout  (fifo_dout),
      .full  (fifo_full),
      .empty (fifo_empty),
      .level (fifo_level)
   );

   crc_word_mirror #(.DW(DW)) u_mirror (
      .din       (fifo_dout),
      .bit_rev   (ctrl_q[C_BITM]),
      .byte_rev  (ctrl_q[C_BYTM]),
      .half_swap (ctrl_q[C_HSWP]),
      .dout      (word_m)
   );

   crc_fold #(.DW(DW)) u_fold (
      .crc_in  (run_q),
      .word    (word_m),
      .poly    (poly_eff),
      .crc_out (fold_out)
   );

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cmp_q  <= '0;
         poly_q <= POLY_RESET;
         ien_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata;
         if (wr_cmp)  cmp_q  <= bus_wdata;
         if (wr_poly) poly_q <= bus_wdata;
         if (wr_iset)      ien_q <= ien_q | (bus_wdata & IEN_MASK);
         else if (wr_iclr) ien_q <= ien_q & ~(bus_wdata & IEN_MASK);
      end
   end

   // polynomial preparation timer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             lut_cnt <= '0;
      else if (wr_poly)       lut_cnt <= LCW'(LUT_CYCLES);
      else if (!lut_done)     lut_cnt <= lut_cnt - 1'b1;
   end

   // datapath state: count, running checksum, result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= '0;
         res_q <= '0;
      end else begin
         if (wr_cnt)   cnt_q <= bus_wdata;
         else if (pop) cnt_q <= cnt_q - 1'b1;
         if (wr_cur)   run_q <= bus_wdata;
         else          run_q <= run_next;
         if (wr_cur)      res_q <= bus_wdata;
         else if (expire) res_q <= run_next;
      end
   end

   // status flags: set has priority over write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_cerr <= 1'b0;
         st_exp  <= 1'b0;
         st_ovf  <= 1'b0;
      end else begin
         if ((expire && (mode == MODE_CALC) && (run_next != cmp_eff)) ||
             (pop && (mode == MODE_VERIFY) && (word_m != cmp_eff)))
            st_cerr <= 1'b1;
         else if (wr_stat && bus_wdata[S_CERR])
            st_cerr <= 1'b0;
         if (expire)                             st_exp <= 1'b1;
         else if (wr_stat && bus_wdata[S_EXP])   st_exp <= 1'b0;
         if (wr_data && fifo_full)               st_ovf <= 1'b1;
         else if (wr_stat && bus_wdata[S_OVF])   st_ovf <= 1'b0;
      end
   end

   always_comb begin
      st_vec          = '0;
      st_vec[S_CERR]  = st_cerr;
      st_vec[S_EXP]   = st_exp;
      st_vec[S_OVF]   = st_ovf;
      st_vec[S_ROOM]  = !fifo_full;
      st_vec[S_READY] = lut_done;
   end

   assign irq = |(st_vec & ien_q);

   always_comb begin
      case (bus_addr)
         A_CTRL:   bus_rdata = ctrl_q;
         A_COUNT:  bus_rdata = cnt_q;
         A_CMP:    bus_rdata = cmp_q;
         A_POLY:   bus_rdata = poly_q;
         A_CUR:    bus_rdata = run_q;
         A_STAT:   bus_rdata = st_vec;
         A_IENSET: bus_rdata = ien_q;
         A_IENCLR: bus_rdata = ien_q;
         A_RESULT: bus_rdata = ctrl_q[C_RESM] ? rev_bits(res_q) : res_q;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/crc_engine_checker.sv
module crc_engine_checker #(
   parameter int FIFO_DEPTH = 4,
   parameter int LVL_W      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq,
   input logic [31:0]      ien_q,
   input logic             en,
   input logic             wr_cnt,
   input logic             wr_poly,
   input logic [31:0]      cnt_q,
   input logic             pop,
   input logic             st_exp,
   input logic             st_ovf,
   input logic             ovf_clr,
   input logic             lut_done,
   input logic [LVL_W-1:0] fifo_level
);

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq); // R12

   AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wr_cnt) |=> $stable(cnt_q)); // R8

   AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && (cnt_q == 32'd1) && !wr_cnt) |=> st_exp); // R6

   AST_LUT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      !lut_done |-> !pop); // R9

   AST_LUT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      wr_poly |=> !lut_done); // R9

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LVL_W'(FIFO_DEPTH)); // R10

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_ovf && !ovf_clr) |=> st_ovf); // R10

endmodule

bind crc_engine crc_engine_checker #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq        (irq),
   .ien_q      (ien_q),
   .en         (ctrl_q[0]),
   .wr_cnt     (wr_cnt),
   .wr_poly    (wr_poly),
   .cnt_q      (cnt_q),
   .pop        (pop),
   .st_exp     (st_exp),
   .st_ovf     (st_ovf),
   .ovf_clr    (wr_stat && bus_wdata[8]),
   .lut_done   (lut_done),
   .fifo_level (fifo_level)
);

// File: tb/crc_engine_test.sv
module crc_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int LUTC       = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   crc_engine #(.FIFO_DEPTH(4), .LUT_CYCLES(LUTC), .POLY_RESET(32'h04C1_1DB7)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct packed {
      logic [6:0]  mir;   // bit0=ctrl16 ... bit6=ctrl22
      logic [31:0] seed;
      logic [31:0] poly;
      logic [1:0]  n;
      logic [31:0] w0;
      logic [31:0] w1;
      logic [31:0] w2;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{7'h00, 32'hFFFF_FFFF, 32'h04C1_1DB7, 2'd3, 32'h0102_0304, 32'h0506_0708, 32'h090A_0B0C},
      '{7'h01, 32'h0000_0000, 32'h04C1_1DB7, 2'd2, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0},
      '{7'h02, 32'h5A5A_5A5A, 32'h1EDC_6F41, 2'd3, 32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC},
      '{7'h04, 32'hFFFF_FFFF, 32'h04C1_1DB7, 2'd1, 32'hDEAD_BEEF, 32'h0, 32'h0},
      '{7'h17, 32'h1234_5678, 32'h8141_41AB, 2'd3, 32'hCAFE_F00D, 32'h0000_0001, 32'h8000_0000},
      '{7'h20, 32'hFFFF_FFFF, 32'hEDB8_8320, 2'd2, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0},
      '{7'h10, 32'h0000_0000, 32'h04C1_1DB7, 2'd1, 32'h0000_0001, 32'h0, 32'h0}
   };

   // ---------------- reference model ----------------
   function automatic logic [31:0] m_rev(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[31-i] = v[i];
      return r;
   endfunction

   function automatic logic [31:0] m_mirror(input logic [31:0] w, input logic [2:0] m);
      logic [31:0] r;
      r = w;
      if (m[0]) for (int b = 0; b < 4; b++) for (int k = 0; k < 8; k++) r[8*b+k] = w[8*b+7-k];
      if (m[1]) r = {r[7:0], r[15:8], r[23:16], r[31:24]};
      if (m[2]) r = {r[15:0], r[31:16]};
      return r;
   endfunction

   function automatic logic [31:0] m_fold(input logic [31:0] c, input logic [31:0] d, input logic [31:0] p);
      logic [31:0] r;
      r = c;
      for (int i = 31; i >= 0; i--) begin
         logic fb;
         fb = r[31] ^ d[i];
         r  = {r[30:0], 1'b0} ^ (fb ? p : 32'h0);
      end
      return r;
   endfunction

   function automatic logic [31:0] ctrl_word(input logic [6:0] mir, input logic [3:0] mode, input logic en);
      return {9'b0, mir, 8'b0, mode, 3'b0, en};
   endfunction

   // ---------------- bus helpers ----------------
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] v, run, pe, exp_crc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd0, v); chk("R1 ctrl", v, 32'h0);
      rd(4'd6, v); chk("R1 status", v, 32'h0009_0000);
      rd(4'd3, v); chk("R1 poly", v, 32'h04C1_1DB7);
      chk("R1 irq", {31'b0, irq}, 32'h0);

      // R2 R4 R5 R6: table walk
      for (int t = 0; t < 7; t++) begin
         vec_t c;
         c = VECS[t];
         wr(4'd3, c.poly);
         idle(LUTC + 2);
         wr(4'd0, ctrl_word(c.mir, 4'd3, 1'b0));
         wr(4'd4, c.seed);
         wr(4'd1, {30'b0, c.n});
         run = c.seed;
         pe  = c.mir[5] ? m_rev(c.poly) : c.poly;
         for (int k = 0; k < 3; k++) begin
            if (k < int'(c.n)) begin
               logic [31:0] w;
               w = (k == 0) ? c.w0 : (k == 1) ? c.w1 : c.w2;
               wr(4'd5, w);
               run = m_fold(run, m_mirror(w, c.mir[2:0]), pe);
            end
         end
         wr(4'd0, ctrl_word(c.mir, 4'd3, 1'b1));
         idle(8);
         exp_crc = c.mir[4] ? m_rev(run) : run;
         rd(4'd9, v); chk($sformatf("R2 R4 R5 vector %0d result", t), v, exp_crc);
         rd(4'd6, v); chk($sformatf("R6 vector %0d expired", t), {31'b0, v[4]}, 32'h1);
         wr(4'd6, 32'hFFFF_FFFF);
         wr(4'd0, 32'h0);
      end
      wr(4'd3, 32'h04C1_1DB7);
      idle(LUTC + 2);

      // R3 zero words
      wr(4'd4, 32'hA5A5_1234);
      rd(4'd9, v); chk("R3 result equals seed", v, 32'hA5A5_1234);
      rd(4'd4, v); chk("R3 running equals seed", v, 32'hA5A5_1234);

      // R8 enable held clear
      wr(4'd0, ctrl_word(7'h0, 4'd3, 1'b0));
      wr(4'd4, 32'h0);
      wr(4'd1, 32'd2);
      wr(4'd5, 32'h1111_1111);
      wr(4'd5, 32'h2222_2222);
      idle(5);
      rd(4'd1, v); chk("R8 count holds", v, 32'd2);
      rd(4'd4, v); chk("R8 checksum holds", v, 32'h0);
      // R6 leftover word: count 1 of 2
      wr(4'd1, 32'd1);
      wr(4'd0, ctrl_word(7'h0, 4'd3, 1'b1));
      idle(4);
      rd(4'd1, v); chk("R6 count reaches zero", v, 32'd0);
      exp_crc = m_fold(32'h0, 32'h1111_1111, 32'h04C1_1DB7);
      rd(4'd9, v); chk("R6 one word folded", v, exp_crc);
      wr(4'd6, 32'h0000_0012);
      wr(4'd1, 32'd1);
      idle(4);
      rd(4'd6, v); chk("R6 leftover word expires", {31'b0, v[4]}, 32'h1);
      exp_crc = m_fold(exp_crc, 32'h2222_2222, 32'h04C1_1DB7);
      rd(4'd9, v); chk("R6 leftover folded", v, exp_crc);

      // R7 compare in mode 3: match then mismatch
      wr(4'd6, 32'hFFFF_FFFF);
      wr(4'd4, 32'hFFFF_FFFF);
      exp_crc = m_fold(32'hFFFF_FFFF, 32'h0BAD_F00D, 32'h04C1_1DB7);
      wr(4'd2, exp_crc);
      wr(4'd1, 32'd1);
      wr(4'd5, 32'h0BAD_F00D);
      idle(4);
      rd(4'd6, v); chk("R7 mode3 match no error", {31'b0, v[1]}, 32'h0);
      wr(4'd4, 32'hFFFF_FFFF);
      wr(4'd2, exp_crc ^ 32'h1);
      wr(4'd1, 32'd1);
      wr(4'd5, 32'h0BAD_F00D);
      idle(4);
      rd(4'd6, v); chk("R7 mode3 mismatch error", {31'b0, v[1]}, 32'h1);
      // R5 compare mirror
      wr(4'd6, 32'hFFFF_FFFF);
      wr(4'd0, ctrl_word(7'h40, 4'd3, 1'b1));
      wr(4'd4, 32'hFFFF_FFFF);
      wr(4'd2, m_rev(exp_crc));
      wr(4'd1, 32'd1);
      wr(4'd5, 32'h0BAD_F00D);
      idle(4);
      rd(4'd6, v); chk("R5 compare mirror match", {31'b0, v[1]}, 32'h0);

      // R7 verify mode 4
      wr(4'd6, 32'hFFFF_FFFF);
      wr(4'd0, ctrl_word(7'h0, 4'd4, 1'b1));
      wr(4'd2, 32'hDEAD_BEEF);
      wr(4'd1, 32'd1);
      wr(4'd5, 32'hDEAD_BEEF);
      idle(4);
      rd(4'd6, v); chk("R7 verify match", {31'b0, v[1]}, 32'h0);
      wr(4'd1, 32'd1);
      wr(4'd5, 32'hDEAD_BEE0);
      idle(4);
      rd(4'd6, v); chk("R7 verify mismatch", {31'b0, v[1]}, 32'h1);

      // R13 fill mode leaves checksum
      wr(4'd6, 32'hFFFF_FFFF);
      wr(4'd0, ctrl_word(7'h0, 4'd2, 1'b1));
      wr(4'd4, 32'h1357_9BDF);
      wr(4'd1, 32'd1);
      wr(4'd5, 32'h5555_AAAA);
      idle(4);
      rd(4'd1, v); chk("R13 word counted", v, 32'd0);
      rd(4'd4, v); chk("R13 checksum unchanged", v, 32'h1357_9BDF);

      // R9 polynomial preparation window
      wr(4'd6, 32'hFFFF_FFFF);
      wr(4'd0, ctrl_word(7'h0, 4'd3, 1'b1));
      wr(4'd1, 32'd1);
      wr(4'd3, 32'h04C1_1DB7);
      wr(4'd5, 32'h0F0F_0F0F);
      rd(4'd6, v); chk("R9 ready low", {31'b0, v[19]}, 32'h0);
      rd(4'd1, v); chk("R9 no consume while preparing", v, 32'd1);
      idle(LUTC + 4);
      rd(4'd6, v); chk("R9 ready high", {31'b0, v[19]}, 32'h1);
      rd(4'd1, v); chk("R9 consumed after ready", v, 32'd0);

      // R10 overflow
      wr(4'd6, 32'hFFFF_FFFF);
      wr(4'd0, ctrl_word(7'h0, 4'd3, 1'b0));
      for (int k = 0; k < 4; k++) wr(4'd5, 32'(k));
      rd(4'd6, v); chk("R10 full no room", {31'b0, v[16]}, 32'h0);
      chk("R10 no overflow yet", {31'b0, v[8]}, 32'h0);
      wr(4'd5, 32'h99);
      rd(4'd6, v); chk("R10 overflow set", {31'b0, v[8]}, 32'h1);
      wr(4'd1, 32'd5);
      wr(4'd0, ctrl_word(7'h0, 4'd3, 1'b1));
      idle(8);
      rd(4'd1, v); chk("R10 dropped word not consumed", v, 32'd1);
      wr(4'd1, 32'd0);

      // R11 write-one-to-clear selectivity
      rd(4'd6, v); chk("R11 overflow still set", {31'b0, v[8]}, 32'h1);
      wr(4'd6, 32'h0000_0010);
      rd(4'd6, v); chk("R11 clearing bit4 keeps bit8", {23'b0, v[8:0]} & 32'h110, 32'h100);
      wr(4'd6, 32'h0000_0100);
      rd(4'd6, v); chk("R11 bit8 cleared", {31'b0, v[8]}, 32'h0);

      // R12 interrupt enables
      wr(4'd1, 32'd1);
      wr(4'd5, 32'h1);
      idle(4);
      chk("R12 irq masked", {31'b0, irq}, 32'h0);
      wr(4'd7, 32'h0000_0010);
      rd(4'd7, v); chk("R12 enable readback", v, 32'h10);
      chk("R12 irq raised", {31'b0, irq}, 32'h1);
      wr(4'd8, 32'h0000_0002);
      #1 chk("R12 clear other bit keeps irq", {31'b0, irq}, 32'h1);
      wr(4'd8, 32'h0000_0010);
      #1 chk("R12 irq dropped", {31'b0, irq}, 32'h0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule